// File: doc/BRIEF.md
# Divided System Clock Enable with Hardware-Released Suspend

This block sits behind a free-running on-chip oscillator, represented here by the block clock. It produces a one-cycle clock-enable pulse for the processor and peripherals. The pulse rate is the oscillator rate divided by a power of two between 1 and 128, chosen by a 3-bit select field in a control register. Software can set a suspend bit in the same register. While that bit is set the enable stays low and the divide counter holds its value.

Only hardware events end a suspend:
- a mismatch on either of two 8-bit watched input ports, where each port has its own compare mask and expected value;
- comparator 0 being enabled while its output is low.

Interrupt configuration has no part in this. All wake inputs pass through a two-stage synchronizer. On wake the suspend bit clears itself, and the divider picks up its count where it stopped. The next enable therefore arrives in the same phase it would have had, so no enable is lost and none is repeated.

Top module: `clkdiv_suspend_ctl`

## Requirements
- R1: With the active select value s (0 to 7), one enable pulse, exactly one cycle wide, is issued every 2^s cycles while not suspended.
- R2: After reset the control register reads 8'h07 (divide by 128) and `suspended` is 0. The first enable pulse comes in the 128th cycle after reset release, counting the first cycle with reset inactive as cycle 1.
- R3: Control register at address 0: bits [2:0] hold the divide select and bit 5 holds the suspend bit. Other bits read 0. Writing 1 to bit 5 sets `suspended`, and from then on `clk_en` stays 0.
- R4: For port p (0 or 1) the compare mask is at address 1+2p and the expected value is at address 2+2p. A port event is raised when ((pins XOR value) AND mask) is non-zero, so pin bits whose mask bit is 0 are ignored.
- R5: A suspend is ended by an event on port 0, an event on port 1, or `cmp0_en`=1 with `cmp0_out`=0. A low `cmp0_out` with `cmp0_en`=0 does not wake the block.
- R6: When a wake ends a suspend, the suspend bit clears in hardware and reads back as 0.
- R7: When a wake input changes just before a rising edge, `suspended` is still 1 after the second rising edge and is 0 after the third. If the wake condition is already present when suspend is written, `suspended` is 1 for exactly one cycle.
- R8: The divide count is frozen while suspended. If suspend is entered on an enable cycle at ratio 2, the first enable after wake comes in the cycle after `suspended` falls.
- R9: A new divide select takes effect only at the terminal count of the current period. The period in progress keeps its full length.
- R10: With select 0 (divide by 1), `clk_en` is 1 on every cycle while not suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| p0_pins | input | 8 | Watched port 0 inputs |
| p1_pins | input | 8 | Watched port 1 inputs |
| cmp0_en | input | 1 | Comparator 0 enabled |
| cmp0_out | input | 1 | Comparator 0 output |
| clk_en | output | 1 | Divided system clock enable |
| suspended | output | 1 | Suspend state (suspend bit value) |

## Verification
The bench builds the block with its default parameters: 3-bit select, 8-bit ports and two synchronizer stages. These defaults make all eight divide ratios reachable, including the 128-cycle reset ratio and the divide-by-1 case. With two synchronizer stages the wake latency is a fixed, checkable three edges. Port masks of 8 bits let the bench flip a masked-off pin and a compared pin on the same port, so it can show that only the compared pin ends a suspend.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
   localparam int REG_W   = 8;
   localparam int ADDR_W  = 3;
   localparam int N_PORTS = 2;

   typedef logic [ADDR_W-1:0] reg_addr_t;

   localparam reg_addr_t ADDR_CTRL = reg_addr_t'(0);

   function automatic reg_addr_t mask_addr(input int p);
      return reg_addr_t'(1 + 2 * p);
   endfunction

   function automatic reg_addr_t value_addr(input int p);
      return reg_addr_t'(2 + 2 * p);
   endfunction
endpackage

// File: rtl/cds_sync.sv
module cds_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cds_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/cds_divider.sv
module cds_divider #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel_req,
   output logic             clk_en,
   output logic [SEL_W-1:0] sel_act,
   output logic [(2**SEL_W)-2:0] div_cnt
);
   localparam int               CNT_W    = (2**SEL_W) - 1;
   localparam logic [SEL_W-1:0] MAXSEL_V = SEL_W'(CNT_W);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;

   logic [CNT_W-1:0] cnt_q;
   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] term;
   logic             at_term;

   // terminal count is 2^sel - 1: all ones shifted down
   assign term    = CNT_MAX >> (MAXSEL_V - sel_q);
   assign at_term = (cnt_q == term);
   assign clk_en  = run & at_term;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sel_q <= MAXSEL_V;
      end else if (run) begin
         if (at_term) begin
            cnt_q <= '0;
            sel_q <= sel_req;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign sel_act = sel_q;
   assign div_cnt = cnt_q;
endmodule

// File: rtl/cds_regs.sv
module cds_regs
   import clkdiv_pkg::*;
#(
   parameter int SEL_W    = 3,
   parameter int PORT_W   = 8,
   parameter int SUSP_BIT = 5
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  reg_addr_t                        wr_addr,
   input  logic [REG_W-1:0]                 wr_data,
   input  reg_addr_t                        rd_addr,
   output logic [REG_W-1:0]                 rd_data,
   input  logic                             wake,
   output logic [SEL_W-1:0]                 sel,
   output logic                             susp,
   output logic [N_PORTS-1:0][PORT_W-1:0]   mask,
   output logic [N_PORTS-1:0][PORT_W-1:0]   value
);
   localparam logic [SEL_W-1:0] SEL_RST = '1;

   logic ctrl_wr;
   assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel  <= SEL_RST;
         susp <= 1'b0;
      end else if (ctrl_wr) begin
         sel  <= wr_data[SEL_W-1:0];
         susp <= wr_data[SUSP_BIT];
      end else if (susp && wake) begin
         susp <= 1'b0;
      end
   end

   for (genvar p = 0; p < N_PORTS; p++) begin : g_port_regs
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mask[p]  <= '0;
            value[p] <= '0;
         end else if (wr_en) begin
            if (wr_addr == mask_addr(p))  mask[p]  <= wr_data[PORT_W-1:0];
            if (wr_addr == value_addr(p)) value[p] <= wr_data[PORT_W-1:0];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_CTRL) begin
         rd_data[SEL_W-1:0] = sel;
         rd_data[SUSP_BIT]  = susp;
      end
      for (int p = 0; p < N_PORTS; p++) begin
         if (rd_addr == mask_addr(p))  rd_data[PORT_W-1:0] = mask[p];
         if (rd_addr == value_addr(p)) rd_data[PORT_W-1:0] = value[p];
      end
   end
endmodule

// File: rtl/clkdiv_suspend_ctl.sv
module clkdiv_suspend_ctl
   import clkdiv_pkg::*;
#(
   parameter int SEL_W       = 3,
   parameter int PORT_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int SUSP_BIT    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [REG_W-1:0]    wr_data,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [REG_W-1:0]    rd_data,
   input  logic [PORT_W-1:0]   p0_pins,
   input  logic [PORT_W-1:0]   p1_pins,
   input  logic                cmp0_en,
   input  logic                cmp0_out,
   output logic                clk_en,
   output logic                suspended
);
   localparam int CNT_W  = (2**SEL_W) - 1;
   localparam int SYNC_W = N_PORTS * PORT_W + 2;
   // comparator output resets high so reset never looks like a wake
   localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, {(SYNC_W-1){1'b0}}};

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("clkdiv_suspend_ctl: SEL_W out of range");
   end
   if (PORT_W < 1 || PORT_W > REG_W) begin : g_bad_port
      $error("clkdiv_suspend_ctl: PORT_W must fit a register");
   end
   if (SUSP_BIT < SEL_W || SUSP_BIT >= REG_W) begin : g_bad_susp
      $error("clkdiv_suspend_ctl: SUSP_BIT overlaps select or exceeds register");
   end

   logic [SEL_W-1:0]                sel_req;
   logic [SEL_W-1:0]                sel_act;
   logic [CNT_W-1:0]                div_cnt;
   logic [N_PORTS-1:0][PORT_W-1:0]  mask;
   logic [N_PORTS-1:0][PORT_W-1:0]  value;
   logic [N_PORTS-1:0][PORT_W-1:0]  pins_s;
   logic [SYNC_W-1:0]               sync_d, sync_q;
   logic                            cmp_en_s, cmp_out_s;
   logic [N_PORTS-1:0]              port_hit;
   logic                            wake_any;

   assign sync_d = {cmp0_out, cmp0_en, p1_pins, p0_pins};

   cds_sync #(
      .W       (SYNC_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sync_d),
      .q     (sync_q)
   );

   assign cmp_out_s = sync_q[SYNC_W-1];
   assign cmp_en_s  = sync_q[SYNC_W-2];

   for (genvar p = 0; p < N_PORTS; p++) begin : g_match
      assign pins_s[p]   = sync_q[p*PORT_W +: PORT_W];
      assign port_hit[p] = |((pins_s[p] ^ value[p]) & mask[p]);
   end

   assign wake_any = (|port_hit) | (cmp_en_s & ~cmp_out_s);

   cds_regs #(
      .SEL_W    (SEL_W),
      .PORT_W   (PORT_W),
      .SUSP_BIT (SUSP_BIT)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .wake    (wake_any),
      .sel     (sel_req),
      .susp    (suspended),
      .mask    (mask),
      .value   (value)
   );

   cds_divider #(
      .SEL_W (SEL_W)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (~suspended),
      .sel_req (sel_req),
      .clk_en  (clk_en),
      .sel_act (sel_act),
      .div_cnt (div_cnt)
   );
endmodule

// File: rtl/clkdiv_suspend_ctl_chk.sv
module clkdiv_suspend_ctl_chk #(
   parameter int SEL_W = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   clk_en,
   input logic                   suspended,
   input logic                   wake,
   input logic                   ctrl_wr,
   input logic                   wr_susp,
   input logic [SEL_W-1:0]       sel_act,
   input logic [(2**SEL_W)-2:0]  div_cnt
);
   // R1: a pulse is one cycle wide unless the newly loaded ratio is 1
   assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en |=> (!clk_en || sel_act == '0));

   // R3: no enable while suspended
   assert_no_en_when_susp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      suspended |-> !clk_en);

   // R3: suspend is only entered through a control write with the bit set
   assert_susp_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(suspended) |-> $past(ctrl_wr && wr_susp));

   // R6: a wake with no competing control write releases suspend
   assert_wake_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (suspended && wake && !ctrl_wr) |=> !suspended);

   // R8: divide count holds while suspended
   assert_cnt_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      suspended |=> $stable(div_cnt));

   // R9: the active select changes only on an enable cycle
   assert_sel_at_term_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> $stable(sel_act));

   // R10: divide by 1 enables every running cycle
   assert_div1_every_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_act == '0 && !suspended) |-> clk_en);
endmodule

bind clkdiv_suspend_ctl clkdiv_suspend_ctl_chk #(.SEL_W(SEL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clk_en    (clk_en),
   .suspended (suspended),
   .wake      (wake_any),
   .ctrl_wr   (wr_en && wr_addr == clkdiv_pkg::ADDR_CTRL),
   .wr_susp   (wr_data[SUSP_BIT]),
   .sel_act   (sel_act),
   .div_cnt   (div_cnt)
);

// File: tb/clkdiv_suspend_ctl_tb_top.sv
module clkdiv_suspend_ctl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [7:0] p0_pins = '0;
   logic [7:0] p1_pins = '0;
   logic       cmp0_en = 1'b0;
   logic       cmp0_out = 1'b1;
   logic       clk_en;
   logic       suspended;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   clkdiv_suspend_ctl dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .p0_pins   (p0_pins),
      .p1_pins   (p1_pins),
      .cmp0_en   (cmp0_en),
      .cmp0_out  (cmp0_out),
      .clk_en    (clk_en),
      .suspended (suspended)
   );

   // select value, expected period in cycles
   localparam int VEC [5][2] = '{'{0, 1}, '{1, 2}, '{3, 8}, '{5, 32}, '{2, 4}};

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int d);
      rd_addr = a;
      #1;
      d = int'(rd_data);
   endtask

   task automatic wait_pulse();
      do @(negedge clk); while (!clk_en);
   endtask

   task automatic period(output int n);
      wait_pulse();
      n = 0;
      do begin @(negedge clk); n++; end while (!clk_en);
   endtask

   // at a negedge showing an enable pulse, write suspend (ratio 2 select)
   task automatic suspend_on_pulse();
      wait_pulse();
      wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h21;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int v, n, cnt_en;
      repeat (3) @(negedge clk);
      chk("R2 clk_en in reset", int'(clk_en), 0);
      rst_n = 1'b1;
      rd(3'd0, v);
      chk("R2 ctrl reset value", v, 8'h07);
      chk("R2 suspended after reset", int'(suspended), 0);
      // first pulse in cycle 128 after release = 127 negedges after release
      n = 0;
      do begin @(negedge clk); n++; end while (!clk_en);
      chk("R2 first pulse cycle", n, 127);

      // R9: select change mid-period keeps the 128-cycle period
      n = 0;
      do begin
         @(negedge clk); n++;
         if (n == 10) begin wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h00; end
         else if (n == 11) wr_en = 1'b0;
      end while (!clk_en);
      chk("R9 period in progress kept", n, 128);
      @(negedge clk);
      chk("R9 new select after terminal", int'(clk_en), 1);

      // R10: divide by 1 every cycle
      cnt_en = 0;
      for (int i = 0; i < 16; i++) begin @(negedge clk); cnt_en += int'(clk_en); end
      chk("R10 enables in 16 cycles", cnt_en, 16);

      // R1: vector table
      for (int k = 0; k < 5; k++) begin
         wr(3'd0, 8'(VEC[k][0]));
         wait_pulse(); wait_pulse();
         period(n);
         chk($sformatf("R1 period sel=%0d", VEC[k][0]), n, VEC[k][1]);
      end

      // suspend set-up: R4 masks/values
      p0_pins = 8'h05; p1_pins = 8'hA0;
      wr(3'd1, 8'h0F); wr(3'd2, 8'h05);
      wr(3'd3, 8'hF0); wr(3'd4, 8'hA0);
      rd(3'd3, v);
      chk("R4 port1 mask readback", v, 8'hF0);
      wr(3'd0, 8'h01);
      repeat (4) @(negedge clk);

      suspend_on_pulse();
      rd(3'd0, v);
      chk("R3 ctrl with suspend", v, 8'h21);
      cnt_en = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); cnt_en += int'(clk_en); end
      chk("R3 no enables while suspended", cnt_en, 0);
      p0_pins = 8'h85;
      repeat (6) @(negedge clk);
      chk("R4 masked bit ignored", int'(suspended), 1);
      p0_pins = 8'h84;
      repeat (2) @(negedge clk);
      chk("R7 still suspended after 2 edges", int'(suspended), 1);
      @(negedge clk);
      chk("R7 woken after 3 edges", int'(suspended), 0);
      chk("R8 no enable on wake cycle", int'(clk_en), 0);
      @(negedge clk);
      chk("R8 next enable in phase", int'(clk_en), 1);
      rd(3'd0, v);
      chk("R6 suspend bit self-cleared", v, 8'h01);
      p0_pins = 8'h05;
      repeat (4) @(negedge clk);

      // R5: port 1 wake
      suspend_on_pulse();
      repeat (4) @(negedge clk);
      p1_pins = 8'hB0;
      repeat (3) @(negedge clk);
      chk("R5 port1 wake", int'(suspended), 0);
      p1_pins = 8'hA0;
      repeat (4) @(negedge clk);

      // R5: comparator low but disabled does not wake; enabled does
      suspend_on_pulse();
      cmp0_out = 1'b0;
      repeat (10) @(negedge clk);
      chk("R5 disabled comparator ignored", int'(suspended), 1);
      cmp0_en = 1'b1;
      repeat (3) @(negedge clk);
      chk("R5 comparator wake", int'(suspended), 0);
      repeat (2) @(negedge clk);

      // R7: condition already true when suspend is written
      wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h21;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R7 immediate wake first cycle", int'(suspended), 1);
      @(negedge clk);
      chk("R7 immediate wake released", int'(suspended), 0);
      cmp0_en = 1'b0; cmp0_out = 1'b1;
      repeat (4) @(negedge clk);

      finish_run();
   end
endmodule